// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives a three-wire serial EEPROM (chip select, serial clock, data in, with one data-out line coming back) from a simple request/response interface on the system clock. A client presents a command code, an address and write data with a valid/ready handshake. The controller builds the serial frame: a leading one, two opcode bits, the address MSB first, and the data for write-type commands. It sends the frame and collects read data. The device puts out one zero bit before its read data, and the controller throws that bit away. Four of the commands share opcode `00` and are told apart by the two highest address bits.

Once a command has started an internal program cycle, the controller ends the frame by taking chip select low. It keeps chip select low for a minimum gap, then raises it again with the clock held low, and watches the data-out line until the device reports ready. If the device is still busy after a programmable number of system cycles, the request ends with an error. An optional write-lock mode sends a write-disable frame after every successful program command, so that a stray write later on does nothing. A configuration input picks 16-bit words with 10 address bits, or 8-bit words with 11 address bits.

Top module: `mw_host`

## Requirements
- R1: `req_ready` is high only while the controller is idle, with chip select low. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Each request that is taken produces exactly one single-cycle `rsp_valid` pulse.
- R2: Every frame runs with chip select high and starts with a 1 bit on the data-in line. The two opcode bits follow, then the address MSB first. Command codes on `req_cmd` are 0 read (opcode 10), 1 write (opcode 01) and 2 erase (opcode 11). The data-in line changes only while the serial clock is low, and the serial clock is low whenever chip select is low.
- R3: Command codes 3 write-enable, 4 write-disable, 5 erase-all and 6 write-all are sent with opcode 00. Their two highest address bits are 11, 00, 10 and 01 respectively, and the lower address bits are zero. Code 7 acts as write-disable.
- R4: With `cfg_wide`=1 the frame carries `req_addr[9:0]` and 16 data bits from `req_wdata[15:0]`. With `cfg_wide`=0 it carries `req_addr[10:0]` and 8 data bits from `req_wdata[7:0]`. Read and write-type frames are 29 or 22 clock pulses long, and address-only frames are 13 or 14.
- R5: On a read, the bit the device drives right after the last address bit is discarded. The next 16 (or 8) bits form `rsp_rdata` MSB first, and in 8-bit mode the upper byte is zero. For commands other than read, `rsp_rdata` is zero.
- R6: After a write, erase, erase-all or write-all frame, chip select goes low for the gap and then high again with the serial clock held low. The request completes once data-out is seen high. Read, write-enable and write-disable requests do no polling.
- R7: If data-out has not gone high within `POLL_MAX` system cycles of polling, the response carries `rsp_err`=1, no write-disable frame is sent, and the controller returns to idle. The next request that succeeds reports `rsp_err`=0.
- R8: With `cfg_auto_lock`=1, a program command that completes without error is followed by one write-disable frame before the response. A later write sent without a new write-enable therefore leaves the stored data unchanged.
- R9: Each high and each low phase of the serial clock lasts `CLK_HALF` system cycles. Chip select stays low for at least `GAP_CYC` system cycles between any two high periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: 16-bit words, 10 address bits; 0: 8-bit words, 11 address bits |
| cfg_auto_lock | input | 1 | Send write-disable after each successful program command |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Word or byte address |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read data |
| rsp_err | output | 1 | Ready-poll timeout |
| mw_cs | output | 1 | Chip select to the EEPROM |
| mw_sk | output | 1 | Serial clock to the EEPROM |
| mw_di | output | 1 | Serial data toward the EEPROM |
| mw_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench runs a behavioural EEPROM against the controller in both word sizes. A byte written at the top 11-bit address and read back through both sizes shows whether the address width and the field positions are right. Writes and erases are tried with and without a prior write-enable, which tells a correct extended opcode, a missing one and the automatic write-disable apart. A device busy for longer than the poll limit separates the timeout path from normal completion. Clock pulses, frames and polling windows are counted per request, which shows frame length, polling and the extra lock frame directly.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      CMD_READ      = 3'd0,
      CMD_WRITE     = 3'd1,
      CMD_ERASE     = 3'd2,
      CMD_WR_ON     = 3'd3,
      CMD_WR_OFF    = 3'd4,
      CMD_ERASE_ALL = 3'd5,
      CMD_WRITE_ALL = 3'd6
   } mw_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_GAP,
      ST_POLL
   } mw_state_e;

   // commands that start an internal program cycle and need polling
   function automatic logic is_program(input logic [2:0] c);
      return (c == CMD_WRITE) || (c == CMD_ERASE) ||
             (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
   endfunction

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
   parameter int CLK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sk,
   output logic slot_end
);
   localparam int HW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

   logic [HW-1:0] cnt;
   logic          ph;
   logic          wrap;

   assign wrap     = (cnt == HW'(CLK_HALF - 1));
   assign slot_end = run && ph && wrap;
   assign sk       = ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         ph  <= ~ph;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9: a phase never ends before CLK_HALF cycles have elapsed
   a_r9_phase_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> (ph == $past(ph)));

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
   import mw_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int WORD_W  = 16,
   parameter int FRAME_W = 3 + ADDR_W + WORD_W,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [2:0]         cmd,
   input  logic               wide,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  wdata,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   len,
   output logic [CNT_W-1:0]   rx_first
);
   localparam int AW_N   = ADDR_W;
   localparam int AW_W   = ADDR_W - 1;
   localparam int BYTE_W = WORD_W / 2;

   logic [1:0]        op;
   logic [1:0]        top;
   logic              use_top;
   logic              has_data;
   logic              is_rd;
   logic [AW_W-1:0]   a_w;
   logic [AW_N-1:0]   a_n;
   logic [WORD_W-1:0] d_w;
   logic [BYTE_W-1:0] d_n;

   always_comb begin
      op       = 2'b00;
      top      = 2'b00;
      use_top  = 1'b0;
      has_data = 1'b0;
      is_rd    = 1'b0;
      case (cmd)
         CMD_READ:      begin op = 2'b10; is_rd = 1'b1; end
         CMD_WRITE:     begin op = 2'b01; has_data = 1'b1; end
         CMD_ERASE:     op = 2'b11;
         CMD_WR_ON:     begin use_top = 1'b1; top = 2'b11; end
         CMD_ERASE_ALL: begin use_top = 1'b1; top = 2'b10; end
         CMD_WRITE_ALL: begin use_top = 1'b1; top = 2'b01; has_data = 1'b1; end
         default:       begin use_top = 1'b1; top = 2'b00; end
      endcase

      a_w = use_top ? {top, {(AW_W-2){1'b0}}} : addr[AW_W-1:0];
      a_n = use_top ? {top, {(AW_N-2){1'b0}}} : addr;
      d_w = has_data ? wdata : '0;
      d_n = has_data ? wdata[BYTE_W-1:0] : '0;

      if (wide) begin
         frame    = {1'b1, op, a_w, d_w, 1'b0};
         len      = (is_rd || has_data) ? CNT_W'(3 + AW_W + WORD_W) : CNT_W'(3 + AW_W);
         rx_first = is_rd ? CNT_W'(3 + AW_W) : CNT_W'(FRAME_W);
      end else begin
         frame    = {1'b1, op, a_n, d_n, {(WORD_W-BYTE_W){1'b0}}};
         len      = (is_rd || has_data) ? CNT_W'(3 + AW_N + BYTE_W) : CNT_W'(3 + AW_N);
         rx_first = is_rd ? CNT_W'(3 + AW_N) : CNT_W'(FRAME_W);
      end
   end

endmodule

// File: rtl/mw_host.sv
module mw_host
   import mw_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int WORD_W   = 16,
   parameter int CLK_HALF = 4,
   parameter int GAP_CYC  = 6,
   parameter int POLL_MAX = 1000,
   parameter bit SYNC_DO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic              cfg_auto_lock,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              mw_cs,
   output logic              mw_sk,
   output logic              mw_di,
   input  logic              mw_do
);
   localparam int FRAME_W = 3 + ADDR_W + WORD_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int WMAX    = (GAP_CYC > POLL_MAX) ? GAP_CYC : POLL_MAX;
   localparam int WC_W    = $clog2(WMAX + 1);

   // elaboration-time parameter checks
   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_chk_word
      $error("WORD_W must be even and at least 4");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("ADDR_W must be at least 3");
   end
   if (CLK_HALF < (SYNC_DO ? 3 : 1)) begin : g_chk_half
      $error("CLK_HALF too small for the data-out sampling path");
   end
   if (GAP_CYC < 2) begin : g_chk_gap
      $error("GAP_CYC must be at least 2");
   end
   if (POLL_MAX < 1) begin : g_chk_poll
      $error("POLL_MAX must be at least 1");
   end

   mw_state_e          st;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   slot, len_q, rx_q;
   logic [WC_W-1:0]    wait_cnt;
   logic [WORD_W-1:0]  rdata;
   logic               need_poll, need_lock, err_q, cs_q, rsp_q;
   logic               do_s, slot_end;
   logic [2:0]         fb_cmd;
   logic [FRAME_W-1:0] fb_frame;
   logic [CNT_W-1:0]   fb_len, fb_rx;

   // data-out sampling path: optional two-flop synchronizer
   if (SYNC_DO) begin : g_do_sync
      logic [1:0] sy;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sy <= 2'b00;
         else        sy <= {sy[0], mw_do};
      end
      assign do_s = sy[1];
   end else begin : g_do_raw
      assign do_s = mw_do;
   end

   assign fb_cmd = (st == ST_IDLE) ? req_cmd : 3'(CMD_WR_OFF);

   mw_frame_build #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .FRAME_W(FRAME_W),
      .CNT_W  (CNT_W)
   ) u_frame (
      .cmd     (fb_cmd),
      .wide    (cfg_wide),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .frame   (fb_frame),
      .len     (fb_len),
      .rx_first(fb_rx)
   );

   mw_sk_gen #(.CLK_HALF(CLK_HALF)) u_sk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == ST_FRAME),
      .sk      (mw_sk),
      .slot_end(slot_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         shreg     <= '0;
         slot      <= '0;
         len_q     <= '0;
         rx_q      <= '0;
         wait_cnt  <= '0;
         rdata     <= '0;
         need_poll <= 1'b0;
         need_lock <= 1'b0;
         err_q     <= 1'b0;
         cs_q      <= 1'b0;
         rsp_q     <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               shreg     <= fb_frame;
               len_q     <= fb_len;
               rx_q      <= fb_rx;
               slot      <= '0;
               rdata     <= '0;
               err_q     <= 1'b0;
               need_poll <= is_program(req_cmd);
               need_lock <= is_program(req_cmd) && cfg_auto_lock;
               cs_q      <= 1'b1;
               st        <= ST_FRAME;
            end
            ST_FRAME: if (slot_end) begin
               if (slot >= rx_q) rdata <= {rdata[WORD_W-2:0], do_s};
               shreg <= shreg << 1;
               slot  <= slot + 1'b1;
               if (slot == len_q - 1'b1) begin
                  cs_q     <= 1'b0;
                  wait_cnt <= '0;
                  st       <= ST_GAP;
               end
            end
            ST_GAP: if (wait_cnt == WC_W'(GAP_CYC - 1)) begin
               wait_cnt <= '0;
               if (need_poll) begin
                  need_poll <= 1'b0;
                  cs_q      <= 1'b1;
                  st        <= ST_POLL;
               end else if (need_lock) begin
                  need_lock <= 1'b0;
                  shreg     <= fb_frame;
                  len_q     <= fb_len;
                  rx_q      <= fb_rx;
                  slot      <= '0;
                  cs_q      <= 1'b1;
                  st        <= ST_FRAME;
               end else begin
                  rsp_q <= 1'b1;
                  st    <= ST_IDLE;
               end
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
            ST_POLL: if (do_s) begin
               cs_q     <= 1'b0;
               wait_cnt <= '0;
               st       <= ST_GAP;
            end else if (wait_cnt == WC_W'(POLL_MAX - 1)) begin
               err_q     <= 1'b1;
               need_lock <= 1'b0;
               cs_q      <= 1'b0;
               wait_cnt  <= '0;
               st        <= ST_GAP;
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata;
   assign rsp_err   = err_q;
   assign mw_cs     = cs_q;
   assign mw_di     = (st == ST_FRAME) ? shreg[FRAME_W-1] : 1'b0;

   // R1: idle implies the bus is released
   a_r1_ready_cs_low : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mw_cs);
   // R1: completion is a single-cycle pulse
   a_r1_rsp_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R2: no clock activity while deselected
   a_r2_sk_low_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      !mw_cs |-> !mw_sk);
   // R2: data-in holds across each rising clock edge
   a_r2_di_stable_rise : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_sk) |-> $stable(mw_di));
   // R6: clock stays low and select high while polling
   a_r6_poll_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POLL) |-> (mw_cs && !mw_sk));
   // R9: a deselect lasts more than one cycle
   a_r9_gap_min : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mw_cs) |=> !mw_cs);

endmodule

// File: tb/mw_host_tb_top.sv
module mw_host_tb_top;
   import mw_pkg::*;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 11;
   localparam int WORD_W = 16;
   localparam int HALF   = 4;
   localparam int GAP    = 6;
   localparam int POLL   = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic              cfg_wide = 1'b1;
   logic              cfg_auto_lock = 1'b0;
   logic              req_valid = 1'b0;
   logic [2:0]        req_cmd = 3'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [WORD_W-1:0] req_wdata = '0;
   logic              req_ready, rsp_valid, rsp_err, mw_cs, mw_sk, mw_di;
   logic [WORD_W-1:0] rsp_rdata;
   logic              mw_do;

   mw_host #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CLK_HALF(HALF),
      .GAP_CYC(GAP), .POLL_MAX(POLL), .SYNC_DO(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_auto_lock(cfg_auto_lock),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mw_cs(mw_cs), .mw_sk(mw_sk),
      .mw_di(mw_di), .mw_do(mw_do)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_req = 0;
   int n_rsp = 0;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (rsp_valid) n_rsp <= n_rsp + 1;

   // ---------------- behavioural EEPROM ----------------
   logic [7:0]  mem [int];
   logic        m_en = 1'b0;
   logic        m_started = 1'b0;
   logic        m_rd = 1'b0;
   logic        m_do = 1'b0;
   logic [31:0] m_sr = '0;
   logic [1:0]  m_op = '0;
   logic [1:0]  m_ext = '0;
   logic [10:0] m_adr = '0;
   logic [15:0] m_rdw = '0;
   logic [15:0] m_dat = '0;
   int          m_nb = 0;
   int          m_pend = 0;
   int          busy_end = 0;
   int          busy_len = 30;
   int          frames = 0;
   int          polls = 0;
   int          rises = 0;
   int          m_aw, m_dw;

   always_comb m_aw = cfg_wide ? ADDR_W - 1 : ADDR_W;
   always_comb m_dw = cfg_wide ? 16 : 8;

   assign mw_do = !mw_cs ? 1'b0 : (m_started ? m_do : (cyc >= busy_end));

   function automatic logic [7:0] mb(input int i);
      return mem.exists(i) ? mem[i] : 8'h00;
   endfunction

   function automatic logic [15:0] rd_word(input logic [10:0] a);
      if (cfg_wide) return {mb(2*int'(a)), mb(2*int'(a)+1)};
      return {mb(int'(a)), 8'h00};
   endfunction

   task automatic wr_word(input logic [10:0] a, input logic [15:0] d);
      if (cfg_wide) begin
         mem[2*int'(a)]   = d[15:8];
         mem[2*int'(a)+1] = d[7:0];
      end else begin
         mem[int'(a)] = d[7:0];
      end
   endtask

   always @(posedge mw_sk or negedge mw_cs) begin
      if (!mw_cs) begin
         if (!m_started) polls++;
         if (m_pend != 0 && m_en) begin
            case (m_pend)
               1: wr_word(m_adr, m_dat);
               2: wr_word(m_adr, 16'hFFFF);
               3: for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
               default: for (int i = 0; i < 2048; i++)
                  mem[i] = cfg_wide ? ((i % 2 == 0) ? m_dat[15:8] : m_dat[7:0]) : m_dat[7:0];
            endcase
            busy_end = cyc + busy_len;
         end
         m_pend    = 0;
         m_started = 1'b0;
         m_rd      = 1'b0;
         m_do      = 1'b0;
      end else begin
         rises++;
         if (!m_started) begin
            if (mw_di) begin
               m_started = 1'b1;
               frames++;
               m_nb = 0;
               m_sr = '0;
            end
         end else begin
            m_sr = {m_sr[30:0], mw_di};
            m_nb++;
            if (m_rd) begin
               m_do  = m_rdw[15];
               m_rdw = m_rdw << 1;
            end
            if (m_nb == 2 + m_aw) begin
               m_op  = 2'(m_sr >> m_aw);
               m_adr = 11'(m_sr) & (cfg_wide ? 11'h3FF : 11'h7FF);
               m_ext = 2'(m_adr >> (m_aw - 2));
               case (m_op)
                  2'b10: begin m_rd = 1'b1; m_do = 1'b0; m_rdw = rd_word(m_adr); end
                  2'b11: m_pend = 2;
                  2'b00: case (m_ext)
                     2'b11: m_en = 1'b1;
                     2'b00: m_en = 1'b0;
                     2'b10: m_pend = 3;
                     default: ;
                  endcase
                  default: ;
               endcase
            end
            if (m_nb == 2 + m_aw + m_dw &&
                (m_op == 2'b01 || (m_op == 2'b00 && m_ext == 2'b01))) begin
               m_dat  = cfg_wide ? m_sr[15:0] : {8'h00, m_sr[7:0]};
               m_pend = (m_op == 2'b01) ? 1 : 4;
            end
         end
      end
   end

   // ---------------- bus timing monitor ----------------
   int sk_hi_run = 0, sk_hi_min = 1000, sk_hi_max = 0;
   int sk_lo_run = 0, sk_lo_min = 1000;
   int cs_lo_run = 0, cs_lo_min = 1000;
   logic seen_cs = 1'b0;
   always @(negedge clk) begin
      if (mw_cs && mw_sk) sk_hi_run++;
      else if (sk_hi_run > 0) begin
         if (sk_hi_run < sk_hi_min) sk_hi_min = sk_hi_run;
         if (sk_hi_run > sk_hi_max) sk_hi_max = sk_hi_run;
         sk_hi_run = 0;
      end
      if (mw_cs && !mw_sk && dut_i.st == ST_FRAME) sk_lo_run++;
      else if (sk_lo_run > 0) begin
         if (sk_lo_run < sk_lo_min) sk_lo_min = sk_lo_run;
         sk_lo_run = 0;
      end
      if (!mw_cs) cs_lo_run++;
      else begin
         if (seen_cs && cs_lo_run > 0 && cs_lo_run < cs_lo_min) cs_lo_min = cs_lo_run;
         if (cs_lo_run > 0) seen_cs = 1'b1;
         cs_lo_run = 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [15:0] r_data;
   logic        r_err;
   int          d_frames, d_polls, d_rises;

   task automatic do_req(input logic [2:0] c, input logic [10:0] a, input logic [15:0] d);
      int n;
      int f0, p0, r0;
      f0 = frames; p0 = polls; r0 = rises;
      @(negedge clk);
      req_cmd = c; req_addr = a; req_wdata = d; req_valid = 1'b1;
      n = 0;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      @(negedge clk);
      req_valid = 1'b0;
      n_req++;
      n = 0;
      while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) begin
         errors++;
         $display("FAIL R1 no response actual=none expected=rsp_valid");
      end
      r_data = rsp_rdata;
      r_err  = rsp_err;
      d_frames = frames - f0;
      d_polls  = polls - p0;
      d_rises  = rises - r0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      @(negedge clk);
      chk("R1", req_ready, 1, "ready after reset");
      chk("R1", {mw_cs, mw_sk, rsp_valid}, 0, "bus and response idle after reset");
   endtask

   task automatic t_wide_rw;
      cfg_wide = 1'b1;
      do_req(CMD_WR_ON, 11'h0, 16'h0);
      chk("R3", d_rises, 13, "write-enable frame pulses x16");
      chk("R6", d_polls, 0, "no polling after write-enable");
      do_req(CMD_WRITE, 11'h155, 16'hA5C3);
      chk("R4", d_rises, 29, "write frame pulses x16");
      chk("R6", d_polls, 1, "one polling window after write");
      chk("R5", r_data, 0, "rdata zero on write");
      chk("R7", r_err, 0, "no error on normal write");
      do_req(CMD_READ, 11'h155, 16'h0);
      chk("R5", r_data, 16'hA5C3, "read back x16");
      chk("R4", d_rises, 29, "read frame pulses x16");
      chk("R6", d_polls, 0, "no polling on read");
   endtask

   task automatic t_narrow_rw;
      cfg_wide = 1'b0;
      do_req(CMD_WR_ON, 11'h0, 16'h0);
      chk("R4", d_rises, 14, "write-enable frame pulses x8");
      do_req(CMD_WRITE, 11'h7FF, 16'hFF5A);
      chk("R4", d_rises, 22, "write frame pulses x8");
      do_req(CMD_READ, 11'h7FF, 16'h0);
      chk("R5", r_data, 16'h005A, "read back x8 top address");
      do_req(CMD_READ, 11'h2AA, 16'h0);
      chk("R4", r_data, 16'h00A5, "x8 read of byte written in x16 mode");
      cfg_wide = 1'b1;
      do_req(CMD_READ, 11'h3FF, 16'h0);
      chk("R4", r_data, 16'h005A, "x16 read of top word");
   endtask

   task automatic t_erase_cmds;
      cfg_wide = 1'b1;
      do_req(CMD_ERASE, 11'h155, 16'h0);
      chk("R2", d_rises, 13, "erase frame pulses");
      chk("R6", d_polls, 1, "erase polls");
      do_req(CMD_READ, 11'h155, 16'h0);
      chk("R2", r_data, 16'hFFFF, "erased word");
      do_req(CMD_WRITE_ALL, 11'h0, 16'h1234);
      chk("R3", d_rises, 29, "write-all frame pulses");
      do_req(CMD_READ, 11'h3FE, 16'h0);
      chk("R3", r_data, 16'h1234, "write-all result");
      do_req(CMD_ERASE_ALL, 11'h0, 16'h0);
      chk("R3", d_polls, 1, "erase-all polls");
      do_req(CMD_READ, 11'h200, 16'h0);
      chk("R3", r_data, 16'hFFFF, "erase-all result");
   endtask

   task automatic t_auto_lock;
      cfg_auto_lock = 1'b1;
      do_req(CMD_WR_ON, 11'h0, 16'h0);
      chk("R8", d_frames, 1, "no lock frame after write-enable");
      do_req(CMD_WRITE, 11'h010, 16'hBEEF);
      chk("R8", d_frames, 2, "write followed by lock frame");
      chk("R8", d_rises, 42, "write plus lock pulses");
      do_req(CMD_READ, 11'h010, 16'h0);
      chk("R8", r_data, 16'hBEEF, "locked write landed");
      do_req(CMD_WRITE, 11'h010, 16'h1111);
      do_req(CMD_READ, 11'h010, 16'h0);
      chk("R8", r_data, 16'hBEEF, "write while disabled ignored");
   endtask

   task automatic t_timeout;
      do_req(CMD_WR_ON, 11'h0, 16'h0);
      busy_len = 1000;
      do_req(CMD_WRITE, 11'h020, 16'h7777);
      chk("R7", r_err, 1, "timeout flagged");
      chk("R7", d_frames, 1, "no lock frame after timeout");
      repeat (1100) @(negedge clk);
      busy_len = 30;
      do_req(CMD_READ, 11'h020, 16'h0);
      chk("R7", r_err, 0, "error cleared on next request");
      chk("R5", r_data, 16'h7777, "data after long program cycle");
      cfg_auto_lock = 1'b0;
   endtask

   task automatic t_timing;
      chk("R9", sk_hi_min, HALF, "shortest clock high phase");
      chk("R9", sk_hi_max, HALF, "longest clock high phase");
      chk("R9", sk_lo_min, HALF, "shortest clock low phase");
      chk("R9", cs_lo_min >= GAP, 1, "deselect gap at least GAP_CYC");
      repeat (3) @(negedge clk);
      chk("R1", n_rsp, n_req, "one response per request");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_wide_rw;
      t_narrow_rw;
      t_erase_cmds;
      t_auto_lock;
      t_timeout;
      t_timing;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule